// File: doc/BRIEF.md
# NAND Page Program and Block Erase Array

This block is a small on-chip byte array that behaves like NAND cells. Each page holds a main area and a spare area one thirty-second of the main size. A host first streams bytes into a page buffer. A program command then merges those bytes into the array. Each byte is ANDed into its cell, so a program can only turn ones into zeros. An erase command returns a whole aligned block of pages, main and spare bytes alike, to 0xFF. Separate logic decodes the commands. It drives this block through plain strobes.

The buffer write port and the read port are valid/ready streams. Both ready outputs are high exactly when the block is idle, so a sender must hold its byte while the block is busy. A read response carries no back-pressure: the reader must take `rsp_data` in the cycle that `rsp_valid` is high. The program and erase sequencers touch one byte per clock. They raise `busy` while they run and pulse `done` when they finish. Commands are ignored when the write-protect input is active or the page index lies past the end of the array.

Top module: `nand_pgm_array`

## Requirements
- R1: After reset every cell reads 0xFF, `busy`, `done` and `rsp_valid` are low, and `wr_ready` and `rd_ready` are high.
- R2: `wr_ready` is high only while idle. `buf_clr` while idle sets the fill count to zero. Each accepted byte is appended to the buffer. Bytes beyond PAGE_TOTAL (main plus spare) are accepted but discarded. `buf_clr` and bytes offered while busy change nothing.
- R3: A program replaces each target cell with (cell AND buffered byte), so bits are only ever cleared.
- R4: Buffered byte i lands at column `op_col` + column offset + i of page `op_page`. Any column at or above PAGE_TOTAL is dropped and never spills into the next page.
- R5: A `pre_load` pulse while idle, with no command starting in that cycle, stores `pre_col` as the column offset. The offset returns to zero when a program completes. An erase leaves it unchanged.
- R6: An erase clears the low log2(PAGES_PER_BLOCK) bits of `op_page` and writes 0xFF to every main and spare byte of the PAGES_PER_BLOCK pages from that base. All other pages are unchanged.
- R7: While `wp_n` is low (protected), `prog_go` and `erase_go` are ignored: `busy` stays low, `done` does not pulse and the array is unchanged.
- R8: A program or erase with `op_page` >= NUM_PAGES is ignored in the same way as in R7.
- R9: `busy` rises in the cycle after a command is accepted. A program keeps `busy` high for fill+1 cycles and an erase for PAGES_PER_BLOCK*PAGE_TOTAL+1 cycles. `done` is a one-cycle pulse in the first cycle that `busy` is low.
- R10: `rd_ready` is high only while idle. An accepted read returns `rsp_valid` with the cell byte in the next cycle. A read with page >= NUM_PAGES or column >= PAGE_TOTAL returns 0xFF.
- R11: `prog_go` and `erase_go` seen while busy are dropped, not queued. When both are raised in the same idle cycle, the program is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect, low blocks program and erase |
| buf_clr | input | 1 | Program setup: reset buffer fill count |
| wr_valid | input | 1 | Buffer byte valid |
| wr_ready | output | 1 | Buffer byte accepted when high with valid |
| wr_data | input | 8 | Buffer byte |
| prog_go | input | 1 | Program confirm strobe |
| erase_go | input | 1 | Erase confirm strobe |
| op_page | input | PAGE_W | Page index for program or erase |
| op_col | input | COL_W | Start column for program |
| pre_load | input | 1 | Load column offset |
| pre_col | input | COL_W | Column offset value |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with valid |
| rd_page | input | PAGE_W | Read page index |
| rd_col | input | COL_W | Read column |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data byte |

## Verification
The hardest situations to reach are commands and buffer traffic that arrive while a sequencer is running, and a program whose offset column runs past the end of the page. The bench raises `erase_go`, `buf_clr` and `wr_valid` in the middle of a short program. Afterwards it shows that the target block was not erased and that the old buffer was programmed again unchanged. It loads an offset near the page end, programs a short buffer, then reads back both that page and the next one to show that the tail was clipped.

// File: rtl/nand_arr_pkg.sv
package nand_arr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_ERASE = 2'd2
  } seq_st_e;

endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH  = 66,
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [7:0]        din,
  input  logic [FILL_W-1:0] rd_idx,
  output logic [FILL_W-1:0] fill,
  output logic [7:0]        dout
);

  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  logic [7:0] store [DEPTH];
  logic       take;

  // a byte is kept only while there is room; extra bytes are swallowed
  assign take = push && !clr && (fill < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
    end else if (clr) begin
      fill <= '0;
    end else if (take) begin
      fill <= fill + FILL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      store[fill] <= din;
    end
  end

  assign dout = store[rd_idx];

endmodule

// File: rtl/nand_cell_array.sv
module nand_cell_array #(
  parameter int ARR_BYTES = 2112,
  parameter int ARR_AW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              and_mode,
  input  logic [ARR_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ARR_AW-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] cells [ARR_BYTES];

  // NAND semantics: a program only clears bits, an erase sets all of them
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) begin
        cells[i] <= 8'hFF;
      end
    end else if (we) begin
      if (and_mode) begin
        cells[waddr] <= cells[waddr] & wdata;
      end else begin
        cells[waddr] <= 8'hFF;
      end
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_arr_pkg::*;
#(
  parameter int PAGE_TOTAL      = 66,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int NUM_PAGES       = 32,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 7,
  parameter int FILL_W          = 7,
  parameter int CNT_W           = 10,
  parameter int ARR_AW          = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic [PAGE_W-1:0] op_page,
  input  logic [COL_W-1:0]  op_col,
  input  logic              pre_load,
  input  logic [COL_W-1:0]  pre_col,
  input  logic [FILL_W-1:0] fill,
  output logic              busy,
  output logic              done,
  output logic [FILL_W-1:0] buf_idx,
  output logic              arr_we,
  output logic              arr_and,
  output logic [ARR_AW-1:0] arr_addr
);

  localparam int BLK_BYTES = PAGES_PER_BLOCK * PAGE_TOTAL;
  localparam int SUM_W     = CNT_W + 2;
  localparam logic [CNT_W-1:0]  BLK_END  = CNT_W'(BLK_BYTES);
  localparam logic [PAGE_W-1:0] NP_L     = PAGE_W'(NUM_PAGES);
  localparam logic [PAGE_W-1:0] BLK_MASK = ~PAGE_W'(PAGES_PER_BLOCK - 1);
  localparam logic [SUM_W-1:0]  COL_END  = SUM_W'(PAGE_TOTAL);

  seq_st_e            st;
  logic [CNT_W-1:0]   cnt;
  logic [ARR_AW-1:0]  base;
  logic [SUM_W-1:0]   start_col;
  logic [FILL_W-1:0]  len;
  logic [COL_W-1:0]   pre_q;
  logic               done_q;
  logic               go_ok;
  logic [SUM_W-1:0]   col_now;
  logic               prog_live;
  logic               erase_live;

  assign go_ok = (st == ST_IDLE) && wp_n && (op_page < NP_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      base      <= '0;
      start_col <= '0;
      len       <= '0;
      pre_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (prog_go && go_ok) begin
            st        <= ST_PROG;
            cnt       <= '0;
            base      <= ARR_AW'(op_page) * ARR_AW'(PAGE_TOTAL);
            start_col <= SUM_W'(op_col) + SUM_W'(pre_q);
            len       <= fill;
          end else if (erase_go && go_ok) begin
            st   <= ST_ERASE;
            cnt  <= '0;
            base <= ARR_AW'(op_page & BLK_MASK) * ARR_AW'(PAGE_TOTAL);
          end else if (pre_load) begin
            pre_q <= pre_col;
          end
        end
        ST_PROG: begin
          if (cnt == CNT_W'(len)) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
            pre_q  <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_ERASE: begin
          if (cnt == BLK_END) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign col_now    = start_col + SUM_W'(cnt);
  assign prog_live  = (st == ST_PROG) && (cnt != CNT_W'(len));
  assign erase_live = (st == ST_ERASE) && (cnt != BLK_END);

  assign arr_we   = (prog_live && (col_now < COL_END)) || erase_live;
  assign arr_and  = (st == ST_PROG);
  assign arr_addr = base + ((st == ST_PROG) ? ARR_AW'(col_now) : ARR_AW'(cnt));
  assign buf_idx  = FILL_W'(cnt);
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/nand_pgm_array.sv
module nand_pgm_array #(
  parameter int  PAGE_BYTES      = 64,
  parameter int  PAGES_PER_BLOCK = 8,
  parameter int  NUM_PAGES       = 32,
  localparam int SPARE_BYTES     = PAGE_BYTES / 32,
  localparam int PAGE_TOTAL      = PAGE_BYTES + SPARE_BYTES,
  localparam int COL_W           = $clog2(PAGE_TOTAL),
  localparam int PAGE_W          = $clog2(NUM_PAGES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              buf_clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic [PAGE_W-1:0] op_page,
  input  logic [COL_W-1:0]  op_col,
  input  logic              pre_load,
  input  logic [COL_W-1:0]  pre_col,
  output logic              busy,
  output logic              done,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [COL_W-1:0]  rd_col,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);

  localparam int ARR_BYTES = NUM_PAGES * PAGE_TOTAL;
  localparam int ARR_AW    = $clog2(ARR_BYTES);
  localparam int BLK_BYTES = PAGES_PER_BLOCK * PAGE_TOTAL;
  localparam int CNT_W     = $clog2(BLK_BYTES + 1);
  localparam int FILL_W    = $clog2(PAGE_TOTAL + 1);
  localparam logic [PAGE_W-1:0] NP_L = PAGE_W'(NUM_PAGES);
  localparam logic [COL_W-1:0]  PT_L = COL_W'(PAGE_TOTAL);

  logic [FILL_W-1:0] fill;
  logic [FILL_W-1:0] buf_idx;
  logic [7:0]        buf_byte;
  logic              arr_we;
  logic              arr_and;
  logic [ARR_AW-1:0] arr_waddr;
  logic [ARR_AW-1:0] arr_raddr;
  logic [7:0]        arr_rdata;
  logic              rd_hit;
  logic              rd_take;
  logic              seq_busy;

  assign wr_ready = !seq_busy;
  assign rd_ready = !seq_busy;
  assign busy     = seq_busy;

  nand_page_buf #(
    .DEPTH  (PAGE_TOTAL),
    .FILL_W (FILL_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (buf_clr && !seq_busy),
    .push   (wr_valid && wr_ready),
    .din    (wr_data),
    .rd_idx (buf_idx),
    .fill   (fill),
    .dout   (buf_byte)
  );

  nand_op_seq #(
    .PAGE_TOTAL      (PAGE_TOTAL),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .NUM_PAGES       (NUM_PAGES),
    .PAGE_W          (PAGE_W),
    .COL_W           (COL_W),
    .FILL_W          (FILL_W),
    .CNT_W           (CNT_W),
    .ARR_AW          (ARR_AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .op_page  (op_page),
    .op_col   (op_col),
    .pre_load (pre_load),
    .pre_col  (pre_col),
    .fill     (fill),
    .busy     (seq_busy),
    .done     (done),
    .buf_idx  (buf_idx),
    .arr_we   (arr_we),
    .arr_and  (arr_and),
    .arr_addr (arr_waddr)
  );

  nand_cell_array #(
    .ARR_BYTES (ARR_BYTES),
    .ARR_AW    (ARR_AW)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (arr_we),
    .and_mode (arr_and),
    .waddr    (arr_waddr),
    .wdata    (buf_byte),
    .raddr    (arr_raddr),
    .rdata    (arr_rdata)
  );

  // read path: out-of-range coordinates read as erased cells
  assign rd_hit    = (rd_page < NP_L) && (rd_col < PT_L);
  assign rd_take   = rd_valid && rd_ready;
  assign arr_raddr = rd_hit ? (ARR_AW'(rd_page) * ARR_AW'(PAGE_TOTAL) + ARR_AW'(rd_col)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'hFF;
    end else begin
      rsp_valid <= rd_take;
      if (rd_take) begin
        rsp_data <= rd_hit ? arr_rdata : 8'hFF;
      end
    end
  end

endmodule

// File: rtl/nand_pgm_array_chk.sv
module nand_pgm_array_chk #(
  parameter int NUM_PAGES = 32,
  parameter int PAGE_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              prog_go,
  input logic              erase_go,
  input logic [PAGE_W-1:0] op_page,
  input logic              busy,
  input logic              done,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid
);

  localparam logic [PAGE_W-1:0] NP_L = PAGE_W'(NUM_PAGES);

  assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wp_n && (op_page < NP_L) && (prog_go || erase_go)) |=> busy);

  assert_done_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_wp_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_n) |=> !busy);

  assert_range_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (op_page >= NP_L)) |=> !busy);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !prog_go && !erase_go) |=> !busy);

  assert_rsp_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);

  assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rsp_valid);

endmodule

bind nand_pgm_array nand_pgm_array_chk #(
  .NUM_PAGES (NUM_PAGES),
  .PAGE_W    (PAGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .prog_go   (prog_go),
  .erase_go  (erase_go),
  .op_page   (op_page),
  .busy      (busy),
  .done      (done),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/sim_nand_pgm_array.sv
module sim_nand_pgm_array;

  localparam int PB   = 64;
  localparam int PPB  = 8;
  localparam int NP   = 32;
  localparam int PT   = PB + PB / 32;
  localparam int BLKB = PPB * PT;
  localparam int PW   = 6;
  localparam int CW   = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          buf_clr = 1'b0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_data = '0;
  logic          prog_go = 1'b0;
  logic          erase_go = 1'b0;
  logic [PW-1:0] op_page = '0;
  logic [CW-1:0] op_col = '0;
  logic          pre_load = 1'b0;
  logic [CW-1:0] pre_col = '0;
  logic          rd_valid = 1'b0;
  logic [PW-1:0] rd_page = '0;
  logic [CW-1:0] rd_col = '0;
  logic          wr_ready, busy, done, rd_ready, rsp_valid;
  logic [7:0]    rsp_data;

  nand_pgm_array u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .buf_clr(buf_clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .prog_go(prog_go), .erase_go(erase_go), .op_page(op_page), .op_col(op_col),
    .pre_load(pre_load), .pre_col(pre_col), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_page(rd_page), .rd_col(rd_col),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #4ns clk = ~clk;

  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] model [NP*PT];
  logic [7:0] tbuf [PT];
  int         tfill = 0;
  int         tpre = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  // scoreboard monitor: pops one expected byte per response
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 response with nothing expected", 1, 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic fill_buf(input int n, input int seed);
    @(negedge clk);
    buf_clr = 1'b1;
    @(negedge clk);
    buf_clr = 1'b0;
    tfill = 0;
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = pat(seed, i);
      chk(wr_ready == 1'b1, "R2 wr_ready while idle", wr_ready, 1);
      if (tfill < PT) begin
        tbuf[tfill] = wr_data;
        tfill++;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic set_pre(input int v);
    @(negedge clk);
    pre_load = 1'b1;
    pre_col  = CW'(v);
    @(negedge clk);
    pre_load = 1'b0;
    tpre = v;
  endtask

  task automatic model_prog(input int page, input int col);
    for (int i = 0; i < tfill; i++) begin
      int c;
      c = col + tpre + i;
      if (c < PT) model[page*PT + c] = model[page*PT + c] & tbuf[i];
    end
    tpre = 0;
  endtask

  task automatic run_op(input bit prog, input bit erase, input int page, input int col,
                        input string tag);
    bit accept;
    int n;
    int expn;
    accept = wp_n && (page < NP) && (prog || erase);
    @(negedge clk);
    prog_go  = prog;
    erase_go = erase;
    op_page  = PW'(page);
    op_col   = CW'(col);
    @(negedge clk);
    prog_go  = 1'b0;
    erase_go = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    if (accept) begin
      expn = prog ? tfill + 1 : BLKB + 1;
      chk(n == expn, {tag, " R9 busy length"}, n, expn);
      chk(done == 1'b1, {tag, " R9 done at end"}, done, 1);
      if (prog) begin
        model_prog(page, col);
      end else begin
        for (int p = (page / PPB) * PPB; p < (page / PPB) * PPB + PPB; p++)
          for (int c = 0; c < PT; c++) model[p*PT + c] = 8'hFF;
      end
    end else begin
      chk(n == 0, {tag, " no busy"}, n, 0);
      chk(done == 1'b0, {tag, " no done"}, done, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done single cycle"}, done, 0);
  endtask

  task automatic read_byte(input int page, input int col, input string tag);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_page  = PW'(page);
    rd_col   = CW'(col);
    exp_q.push_back((page < NP && col < PT) ? model[page*PT + col] : 8'hFF);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " response count"}, exp_q.size(), 0);
  endtask

  task automatic read_page(input int page, input string tag);
    for (int c = 0; c < PT; c++) begin
      @(negedge clk);
      rd_valid = 1'b1;
      rd_page  = PW'(page);
      rd_col   = CW'(c);
      exp_q.push_back(model[page*PT + c]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_valid = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " response count"}, exp_q.size(), 0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1200us;
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    for (int i = 0; i < NP*PT; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0, "R1 busy low", busy, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    chk(wr_ready == 1'b1, "R1 wr_ready high", wr_ready, 1);
    chk(rd_ready == 1'b1, "R1 rd_ready high", rd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid low", rsp_valid, 0);
    read_page(0, "R1 erased page 0");
    read_page(NP - 1, "R1 erased last page");

    // R2 overflow and R3 first program
    fill_buf(PT + 4, 1);
    chk(tfill == PT, "R2 bench fill clip", tfill, PT);
    run_op(1'b1, 1'b0, 5, 0, "R3 first program");
    read_page(5, "R3 programmed page");
    read_page(4, "R3 neighbour untouched");

    // R3 AND merge
    fill_buf(PT, 2);
    run_op(1'b1, 1'b0, 5, 0, "R3 and merge");
    read_page(5, "R3 and merge data");

    // R4 offset and clipping at page end
    fill_buf(10, 3);
    set_pre(60);
    run_op(1'b1, 1'b0, 9, 3, "R4 offset program");
    read_page(9, "R4 offset data");
    read_page(10, "R4 no spill into next page");

    // R5 offset cleared after program
    fill_buf(2, 4);
    run_op(1'b1, 1'b0, 11, 0, "R5 program after offset");
    read_page(11, "R5 offset cleared");

    // R7 write protect
    wp_n = 1'b0;
    fill_buf(PT, 5);
    run_op(1'b1, 1'b0, 12, 0, "R7 protected program");
    run_op(1'b0, 1'b1, 5, 0, "R7 protected erase");
    read_page(12, "R7 page unchanged");
    read_page(5, "R7 block unchanged");
    wp_n = 1'b1;

    // R8 out of range and R10 out-of-range reads
    run_op(1'b1, 1'b0, 40, 0, "R8 program out of range");
    run_op(1'b0, 1'b1, 63, 0, "R8 erase out of range");
    read_page(8, "R8 alias page untouched");
    read_page(NP - 1, "R8 alias last page untouched");
    read_byte(40, 0, "R10 page out of range");
    read_byte(3, PT + 2, "R10 column out of range");

    // R6 erase of an aligned block
    fill_buf(PT, 6);
    run_op(1'b1, 1'b0, 16, 0, "R6 prep next block");
    fill_buf(PT, 7);
    run_op(1'b1, 1'b0, 15, 0, "R6 prep last page");
    run_op(1'b0, 1'b1, 13, 0, "R6 erase");
    read_page(9, "R6 erased page 9");
    read_page(11, "R6 erased page 11");
    read_page(15, "R6 erased last page of block");
    read_page(5, "R6 other block kept");
    read_page(16, "R6 next block kept");

    // R11 priority and commands while busy
    fill_buf(4, 8);
    run_op(1'b1, 1'b1, 20, 0, "R11 program wins");
    read_page(20, "R11 program wins data");
    @(negedge clk);
    prog_go = 1'b1;
    op_page = PW'(21);
    op_col  = '0;
    @(negedge clk);
    prog_go  = 1'b0;
    erase_go = 1'b1;
    op_page  = PW'(5);
    buf_clr  = 1'b1;
    wr_valid = 1'b1;
    wr_data  = 8'h00;
    chk(busy == 1'b1, "R11 busy during program", busy, 1);
    chk(wr_ready == 1'b0, "R2 wr_ready low while busy", wr_ready, 0);
    chk(rd_ready == 1'b0, "R10 rd_ready low while busy", rd_ready, 0);
    @(negedge clk);
    erase_go = 1'b0;
    buf_clr  = 1'b0;
    wr_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R11 erase not queued", busy, 0);
    model_prog(21, 0);
    read_page(21, "R11 program data");
    read_page(5, "R11 erase dropped");
    run_op(1'b1, 1'b0, 22, 0, "R2 buffer kept after busy traffic");
    read_page(22, "R2 buffer kept data");

    report();
  end

endmodule